// File: doc/BRIEF.md
# DMA Channel Error Flag Bank

This block keeps one sticky error flag per channel of a multi-channel DMA engine. Sixteen channels are the default. The engine raises a one-cycle pulse on a channel's error input, and that channel's flag stays set until software clears it. Software has two ways to clear flags, and both reach the same flag bits:

- a bitmap write to the status register, where each one in the write data clears one flag;
- a write to a single-channel clear register that carries a channel number, plus modifier bits.

A per-channel enable register gates each flag onto that channel's own error interrupt line. A registered summary output is high when any enabled flag is set. Reading the status register always returns the raw flags, whatever the enables hold. The channel completion indications pass straight through the block and are unchanged by any error state.

The register bus is simple. A one-cycle write strobe comes with a 2-bit register select, and read data is combinational. Reset is asynchronous and active-low. It is assumed to be released synchronously by a reset synchronizer outside this block.

Top module: `dma_err_bank`

## Requirements
- R1: A high `err_pulse[i]` at a clock edge sets flag i. Pulses on several channels in the same cycle are all recorded. A flag stays set until it is cleared.
- R2: Reading select 0 (status) returns the raw flags in bits [NUM_CH-1:0], independent of the enable register.
- R3: A write to select 0 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are unchanged.
- R4: A write to select 2 (single clear) with bits 6 and 7 low clears only the flag of the channel numbered by write-data bits [3:0].
- R5: A write to select 2 with bit 6 high and bit 7 low clears all flags, whatever bits [3:0] hold.
- R6: A write to select 2 with bit 7 high changes no flag, even when bit 6 is also high.
- R7: When an error pulse and any clear hit the same channel in the same cycle, the flag ends up set.
- R8: Select 1 is a read/write enable register. `err_irq[i]` is high exactly when flag i and enable bit i are both 1.
- R9: `err_any` is high one cycle after any `err_irq` bit is high, and low one cycle after all are low.
- R10: `done_out` equals `done_in` at all times, whatever the error flags hold.
- R11: While `rst_n` is low, all flags, enables, `err_irq` and `err_any` are zero. Reset takes effect without waiting for a clock edge.
- R12: Reads of select 2 and select 3 return zero. Writes to select 3 change no flag or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse | input | NUM_CH | One-cycle error pulses from the engine, one per channel |
| done_in | input | NUM_CH | Channel completion indications from the engine |
| done_out | output | NUM_CH | Completion indications passed through unchanged |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_sel | input | 2 | Register select: 0 status, 1 enable, 2 single clear, 3 unused |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for the selected register |
| err_irq | output | NUM_CH | Per-channel error interrupt, flag AND enable |
| err_any | output | 1 | Registered OR of all error interrupts |

## Verification
The block's main job is tried with several input patterns:

- single-channel pulses and multi-channel bursts in one cycle;
- an all-channel burst;
- pulses that land in the same cycle as a bitmap clear, an indexed clear or a clear-all.

These patterns separate true recording from lost or merged updates, and they show whether set-over-clear priority holds on every clear path. The clear-register writes cover each combination of the skip and all bits, and an unused select. This tells a correct decode apart from one that ignores a modifier or ranks the two modifiers the wrong way. Enable patterns that mask some set flags while leaving others visible show that the gating acts only on the interrupt lines and never on the status read. The summary output is checked one cycle after the enables change, to confirm its one-register delay.

// File: rtl/dma_err_pkg.sv
`timescale 1ns/1ps
package dma_err_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CLRONE = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  // Modifier bit positions inside the single-channel clear write
  localparam int CLR_ALL_POS  = 6;
  localparam int CLR_SKIP_POS = 7;

endpackage

// File: rtl/err_clr_decode.sv
`timescale 1ns/1ps
module err_clr_decode
  import dma_err_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16
) (
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] clr_mask,
  output logic              en_we,
  output logic [NUM_CH-1:0] en_wdata
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] idx_hit;

  // One comparator per channel for the indexed clear
  for (genvar i = 0; i < NUM_CH; i++) begin : g_idx
    assign idx_hit[i] = (wdata[IDX_W-1:0] == IDX_W'(i));
  end

  assign en_wdata = wdata[NUM_CH-1:0];

  always_comb begin
    clr_mask = '0;
    en_we    = 1'b0;
    if (wr) begin
      case (sel)
        SEL_STATUS: clr_mask = wdata[NUM_CH-1:0];
        SEL_ENABLE: en_we    = 1'b1;
        SEL_CLRONE: begin
          if (!wdata[CLR_SKIP_POS]) begin
            if (wdata[CLR_ALL_POS]) clr_mask = '1;
            else                    clr_mask = idx_hit;
          end
        end
        default: ;
      endcase
    end
  end

  // R6: a skip write never produces a clear
  always_comb begin
    if (wr && (sel == SEL_CLRONE) && wdata[CLR_SKIP_POS])
      p_skip_no_clear_r6: assert (clr_mask == '0);
  end

endmodule

// File: rtl/err_flag_cell.sv
`timescale 1ns/1ps
module err_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_d;

  // Next state: a new error outranks a clear in the same cycle
  always_comb begin
    flag_d = set | (flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set) |=> (flag == $past(flag)));

endmodule

// File: rtl/err_irq_gate.sv
`timescale 1ns/1ps
module err_irq_gate #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flags,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] en_wdata,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] irq,
  output logic              any_q
);

  logic [NUM_CH-1:0] en_d;
  logic              any_d;

  always_comb begin
    en_d  = en_we ? en_wdata : en_q;
    irq   = flags & en_q;
    any_d = |irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      any_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      any_q <= any_d;
    end
  end

  p_en_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(en_wdata)));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));

endmodule

// File: rtl/dma_err_bank.sv
`timescale 1ns/1ps
module dma_err_bank
  import dma_err_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] err_pulse,
  input  logic [NUM_CH-1:0] done_in,
  output logic [NUM_CH-1:0] done_out,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] err_irq,
  output logic              err_any
);

  logic [NUM_CH-1:0] clr_mask;
  logic              en_we;
  logic [NUM_CH-1:0] en_wdata;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] en_q;

  err_clr_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
    .wr       (bus_wr),
    .sel      (bus_sel),
    .wdata    (bus_wdata),
    .clr_mask (clr_mask),
    .en_we    (en_we),
    .en_wdata (en_wdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    err_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_pulse[c]),
      .clr   (clr_mask[c]),
      .flag  (flags[c])
    );
  end

  err_irq_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .en_q     (en_q),
    .irq      (err_irq),
    .any_q    (err_any)
  );

  // Completion indications are not touched by error state
  assign done_out = done_in;

  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      SEL_STATUS: bus_rdata = DATA_W'(flags);
      SEL_ENABLE: bus_rdata = DATA_W'(en_q);
      default:    bus_rdata = '0;
    endcase
  end

  // R8: no interrupt without its flag
  always_comb begin
    p_irq_needs_flag_r8: assert ((err_irq & ~flags) == '0);
  end

  p_any_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> $past(|err_irq));

  p_skip_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_CLRONE && bus_wdata[CLR_SKIP_POS] && err_pulse == '0)
      |=> (flags == $past(flags)));

  p_rsvd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_RSVD && err_pulse == '0)
      |=> ($stable(flags) && $stable(en_q)));

endmodule

// File: tb/test_dma_err_bank.sv
`timescale 1ns/1ps
module test_dma_err_bank;

  localparam int N = 16;
  localparam int W = 16;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  err_pulse;
  logic [N-1:0]  done_in;
  logic [N-1:0]  done_out;
  logic          bus_wr;
  logic [1:0]    bus_sel;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  bus_rdata;
  logic [N-1:0]  err_irq;
  logic          err_any;

  int n_checks = 0;
  int n_fails  = 0;
  logic [N-1:0] en_model = '0;

  dma_err_bank #(.NUM_CH(N), .DATA_W(W)) i_dma_err_bank (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .done_in(done_in),
    .done_out(done_out), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_irq(err_irq),
    .err_any(err_any)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [15:0] err;
    logic        wr;
    logic [1:0]  sel;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  // err, wr, sel, wdata, expected status
  localparam vec_t VECS [16] = '{
    '{16'h0001, 1'b0, 2'd0, 16'h0000, 16'h0001},  // R1 single
    '{16'h8010, 1'b0, 2'd0, 16'h0000, 16'h8011},  // R1 burst
    '{16'h0000, 1'b1, 2'd1, 16'h8001, 16'h8011},  // R8 enable, R2 raw
    '{16'h0000, 1'b1, 2'd0, 16'h0010, 16'h8001},  // R3 clear bit 4
    '{16'h0000, 1'b1, 2'd0, 16'h0000, 16'h8001},  // R3 zeros ignored
    '{16'h0000, 1'b1, 2'd2, 16'h000F, 16'h0001},  // R4 index 15
    '{16'h0001, 1'b1, 2'd2, 16'h0000, 16'h0001},  // R7 indexed vs set
    '{16'h00F0, 1'b0, 2'd0, 16'h0000, 16'h00F1},  // R1
    '{16'h0000, 1'b1, 2'd2, 16'h0084, 16'h00F1},  // R6 skip
    '{16'h0000, 1'b1, 2'd2, 16'h0040, 16'h0000},  // R5 clear all
    '{16'hFFFF, 1'b0, 2'd0, 16'h0000, 16'hFFFF},  // R1 all channels
    '{16'h0100, 1'b1, 2'd0, 16'hFFFF, 16'h0100},  // R7 bitmap vs set
    '{16'h0000, 1'b1, 2'd2, 16'h00C0, 16'h0100},  // R6 skip beats all
    '{16'h0000, 1'b1, 2'd3, 16'hFFFF, 16'h0100},  // R12 unused select
    '{16'h0000, 1'b1, 2'd2, 16'h0048, 16'h0000},  // R5 all ignores index
    '{16'h0402, 1'b1, 2'd2, 16'h0040, 16'h0402}   // R7 clear-all vs set
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_read(input logic [1:0] sel);
    err_pulse = '0;
    bus_wr    = 1'b0;
    bus_sel   = sel;
    bus_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    done_in = '0;
    idle_read(2'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R11 status in reset", bus_rdata, 0);
    check("R11 irq in reset", err_irq, 0);
    check("R11 any in reset", err_any, 0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_sel = 2'd1;
    #1;
    check("R11 enable after reset", bus_rdata, 0);

    // Table walk
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      err_pulse = VECS[k].err;
      bus_wr    = VECS[k].wr;
      bus_sel   = VECS[k].sel;
      bus_wdata = VECS[k].wdata;
      if (VECS[k].wr && VECS[k].sel == 2'd1) en_model = VECS[k].wdata;
      @(posedge clk);
      @(negedge clk);
      idle_read(2'd0);
      #1;
      check($sformatf("R1-table status row %0d", k), bus_rdata, VECS[k].exp);
      check($sformatf("R8 irq row %0d", k), err_irq, VECS[k].exp & en_model);
    end

    // R2 / R8: enable readback, status raw
    bus_sel = 2'd1;
    #1;
    check("R8 enable readback", bus_rdata, en_model);
    bus_sel = 2'd2;
    #1;
    check("R12 clear register reads zero", bus_rdata, 0);
    bus_sel = 2'd3;
    #1;
    check("R12 unused select reads zero", bus_rdata, 0);

    // R9: summary timing (status is 0402, enable 8001)
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 16'h0400; en_model = 16'h0400;
    @(posedge clk);
    @(negedge clk);
    idle_read(2'd0);
    #1;
    check("R8 irq after enable", err_irq, 16'h0400);
    check("R9 any delayed one cycle", err_any, 0);
    @(negedge clk);
    #1;
    check("R9 any high", err_any, 1);
    check("R2 status raw under mask", bus_rdata, 16'h0402);
    bus_wr = 1'b1; bus_sel = 2'd0; bus_wdata = 16'h0400;
    @(posedge clk);
    @(negedge clk);
    idle_read(2'd0);
    #1;
    check("R3 irq gone after clear", err_irq, 0);
    check("R9 any still high one cycle", err_any, 1);
    @(negedge clk);
    #1;
    check("R9 any low", err_any, 0);
    check("R3 remaining flag", bus_rdata, 16'h0002);

    // R10: completion pass-through while errors are present
    done_in = 16'hA5C3;
    #1;
    check("R10 done pass-through", done_out, 16'hA5C3);
    done_in = 16'h0002;
    #1;
    check("R10 done on errored channel", done_out, 16'h0002);

    // R11: asynchronous reset mid-run
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = 2'd1; bus_wdata = 16'hFFFF;
    @(posedge clk);
    @(negedge clk);
    idle_read(2'd0);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R11 status cleared async", bus_rdata, 0);
    bus_sel = 2'd1;
    #0.2;
    check("R11 enable cleared async", bus_rdata, 0);
    check("R11 irq cleared async", err_irq, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule